// File: doc/BRIEF.md
# Deep-Sleep GPIO Wakeup Detector

This block keeps general-purpose input transitions observable while the main bus clock is switched off for deep sleep. A glitch-free clock switch feeds the detection logic either from the divided system clock or from a slow on-chip clock. Each pin goes through a synchronizer and a two-sample stability filter. An accepted rising or falling edge sets the pin's bit in a status register that is cleared by writing ones. While any status bit is set, a level wakeup output is held high.

Power management uses a clock-stop handshake to get the block ready for sleep. When wakeup is enabled, a stop request does not stop the block's clock: it is acknowledged back directly, and detection keeps running. When wakeup is disabled, the acknowledged stop gates the detection clock off. The status register has no clock-domain bridge, so it can be reached only while the block is settled on the system clock and no stop is acknowledged. Every other access goes to a null responder, which completes it with zero data and no error.

The bus is a single-beat interface on the system clock. A request is a one-cycle pulse, and the response arrives one cycle later. Reads return the status register. Writes clear status bits.

Top module: `wake_gpio_keeper`

## Requirements
- R1: The detection clock `gpio_clk` follows `sys_clk` when `slow_sel`=0 and `slow_clk` when `slow_sel`=1. The two source enables are never on together (break before make). `mux_done` is high once the selected source alone drives the output.
- R2: After reset the block runs on the system clock with `mux_done`=1, `cstop_ack`=0, `wake_irq`=0, `bus_err`=0, and status reads as zero.
- R3: `cstop_ack` equals `cstop_req` delayed by one `sys_clk` cycle. With `wake_en`=1 the detection clock keeps running during clock-stop, so pin edges are still latched.
- R4: With `wake_en`=0, an acknowledged clock-stop halts the detection clock. Pin changes made during the stop are not latched until the stop is released, after which they are.
- R5: While `cstop_ack`=1, or while the mux is not settled on the system clock, a request is answered by the null responder. It answers one cycle later with `bus_ack`=1, `bus_rdata`=0 and `bus_err`=0, and a write has no effect on status.
- R6: Otherwise a request with `bus_we`=0 returns the status register on `bus_rdata` with `bus_ack`=1 one cycle later. A request with `bus_we`=1 clears exactly the status bits whose `bus_wdata` bit is 1. Status bit i belongs to `pin_in[i]`.
- R7: Both rising and falling edges are accepted. A new level is accepted only after two consecutive equal detection-clock samples, so a level held for one sample is ignored. An accepted change made before detection edge k shows in status after edge k+3.
- R8: `wake_irq` is high exactly while at least one status bit is set.
- R9: When an event and a write-one-to-clear hit the same bit on the same edge, the bit stays set.
- R10: With the system clock stopped and the block on the slow clock, a pin transition still sets status and raises `wake_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Divided system clock; bus and handshake clock |
| slow_clk | input | 1 | Slow on-chip clock used during sleep |
| rst | input | 1 | Synchronous active-high reset (system clock domain) |
| wake_en | input | 1 | 1: clock-stop is acknowledged without stopping detection |
| slow_sel | input | 1 | Clock source select: 0 system, 1 slow |
| cstop_req | input | 1 | Clock-stop request |
| cstop_ack | output | 1 | Clock-stop acknowledge |
| gpio_clk | output | 1 | Muxed detection clock |
| mux_done | output | 1 | Mux settled on the selected source |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| wake_irq | output | 1 | Level wakeup, high while any status bit is set |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1: write-one-to-clear, 0: read |
| bus_wdata | input | NUM_PINS | Clear mask for writes |
| bus_rdata | output | NUM_PINS | Read data |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Error response, always low |

## Verification
A bus response is due one system-clock cycle after the request edge. A `cstop_ack` change is also due one cycle after the request edge. A pin change driven before detection edge k reaches status and `wake_irq` after edge k+3. The bench drives every input on a falling edge and counts falling edges to the first one after the edge where each result is due, then samples there. It also checks the cycle just before that edge for the latency case. Where the detection clock runs on the slow source or the system clock is halted, the bench counts rising edges of `gpio_clk` instead. It measures that clock's period to confirm which source drives it.

// File: rtl/wgk_pkg.sv
`timescale 1ns/1ps
package wgk_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_SLOW = 1'b1
    } clk_src_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_CLEAR = 2'd2
    } acc_e;

    typedef struct packed {
        logic en_sys;
        logic seen_slow;
    } mux_view_t;

    function automatic logic mux_settled(clk_src_e src, mux_view_t v);
        if (src == SRC_SLOW) return v.seen_slow && !v.en_sys;
        return v.en_sys && !v.seen_slow;
    endfunction

    function automatic acc_e decode_access(logic req, logic we, logic blocked);
        if (!req || blocked) return ACC_NONE;
        return we ? ACC_CLEAR : ACC_READ;
    endfunction

endpackage

// File: rtl/wgk_sync.sv
`timescale 1ns/1ps
module wgk_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wgk_clk_mux.sv
`timescale 1ns/1ps
module wgk_clk_mux
    import wgk_pkg::*;
(
    input  logic     sys_clk,
    input  logic     slow_clk,
    input  logic     rst,
    input  clk_src_e src,
    input  logic     hold_off,
    output logic     clk_out,
    output logic     done,
    output logic     en_sys,
    output logic     en_slow
);
    logic rst_slow;
    logic want_sys, want_slow, want_slow_s;
    logic sys_seen, slow_seen;
    mux_view_t view;

    // reset brought into the slow domain
    wgk_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_rst_slow (
        .clk(slow_clk), .rst(1'b0), .d(rst), .q(rst_slow)
    );

    assign want_sys  = (src == SRC_SYS)  && !hold_off;
    assign want_slow = (src == SRC_SLOW) && !hold_off;

    wgk_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_want_slow (
        .clk(slow_clk), .rst(rst_slow), .d(want_slow), .q(want_slow_s)
    );

    wgk_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sys_seen (
        .clk(slow_clk), .rst(rst_slow), .d(en_sys), .q(sys_seen)
    );

    wgk_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_slow_seen (
        .clk(sys_clk), .rst(rst), .d(en_slow), .q(slow_seen)
    );

    // enables change only while their own clock is low
    always_ff @(negedge sys_clk) begin
        if (rst) en_sys <= 1'b1;
        else     en_sys <= want_sys && !slow_seen;
    end

    always_ff @(negedge slow_clk) begin
        if (rst_slow) en_slow <= 1'b0;
        else          en_slow <= want_slow_s && !sys_seen;
    end

    always_comb begin
        clk_out        = (sys_clk & en_sys) | (slow_clk & en_slow);
        view.en_sys    = en_sys;
        view.seen_slow = slow_seen;
        done           = mux_settled(src, view);
    end
endmodule

// File: rtl/wgk_cstop_gate.sv
`timescale 1ns/1ps
module wgk_cstop_gate
    import wgk_pkg::*;
(
    input  logic     sys_clk,
    input  logic     rst,
    input  logic     cstop_req,
    input  logic     wake_en,
    input  clk_src_e src,
    input  logic     mux_done,
    input  logic     bus_req,
    output logic     cstop_ack,
    output logic     hold_off,
    output logic     gated,
    output logic     gated_q,
    output logic     null_ack
);
    logic on_sys;

    assign on_sys   = mux_done && (src == SRC_SYS);
    assign gated    = cstop_ack || !on_sys;
    assign hold_off = cstop_ack && !wake_en;

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            cstop_ack <= 1'b0;
            gated_q   <= 1'b0;
            null_ack  <= 1'b0;
        end else begin
            cstop_ack <= cstop_req;
            gated_q   <= gated;
            null_ack  <= bus_req && gated;
        end
    end
endmodule

// File: rtl/wgk_edge_det.sv
`timescale 1ns/1ps
module wgk_edge_det #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic evt
);
    logic [DEPTH:0] shift;
    logic           level;

    // newest synchronized sample vs the one before it
    assign evt = (shift[DEPTH-1] == shift[DEPTH]) && (shift[DEPTH-1] != level);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift <= {(DEPTH+1){pin}};
            level <= pin;
        end else begin
            shift <= {shift[DEPTH-1:0], pin};
            if (evt) level <= shift[DEPTH-1];
        end
    end
endmodule

// File: rtl/wgk_status_regs.sv
`timescale 1ns/1ps
module wgk_status_regs
    import wgk_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  acc_e         acc,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic         reg_ack,
    output logic [N-1:0] reg_rdata
);
    logic [N-1:0] clr_mask;

    assign clr_mask = (acc == ACC_CLEAR) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= '0;
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_ack   <= (acc != ACC_NONE);
            reg_rdata <= (acc == ACC_READ) ? status : '0;
            status    <= (status & ~clr_mask) | evt;  // set wins
        end
    end
endmodule

// File: rtl/wake_gpio_keeper.sv
`timescale 1ns/1ps
module wake_gpio_keeper
    import wgk_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                sys_clk,
    input  logic                slow_clk,
    input  logic                rst,
    input  logic                wake_en,
    input  logic                slow_sel,
    input  logic                cstop_req,
    output logic                cstop_ack,
    output logic                gpio_clk,
    output logic                mux_done,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                wake_irq,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic                bus_ack,
    output logic                bus_err
);
    clk_src_e            src;
    acc_e                acc;
    logic                hold_off, gated, gated_q, null_ack;
    logic                en_sys, en_slow;
    logic [NUM_PINS-1:0] evt, status, reg_rdata;
    logic                reg_ack, reg_live;

    assign src = clk_src_e'(slow_sel);

    wgk_clk_mux u_mux (
        .sys_clk(sys_clk), .slow_clk(slow_clk), .rst(rst), .src(src),
        .hold_off(hold_off), .clk_out(gpio_clk), .done(mux_done),
        .en_sys(en_sys), .en_slow(en_slow)
    );

    wgk_cstop_gate u_gate (
        .sys_clk(sys_clk), .rst(rst), .cstop_req(cstop_req), .wake_en(wake_en),
        .src(src), .mux_done(mux_done), .bus_req(bus_req),
        .cstop_ack(cstop_ack), .hold_off(hold_off), .gated(gated),
        .gated_q(gated_q), .null_ack(null_ack)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        wgk_edge_det #(.DEPTH(SYNC_DEPTH)) u_det (
            .clk(gpio_clk), .rst(rst), .pin(pin_in[p]), .evt(evt[p])
        );
    end

    assign acc = decode_access(bus_req, bus_we, gated);

    wgk_status_regs #(.N(NUM_PINS)) u_regs (
        .clk(gpio_clk), .rst(rst), .evt(evt), .acc(acc), .wdata(bus_wdata),
        .status(status), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    // a stale register response is masked once the path is gated
    assign reg_live  = reg_ack && !gated_q;
    assign bus_ack   = reg_live || null_ack;
    assign bus_rdata = reg_live ? reg_rdata : '0;
    assign bus_err   = 1'b0;
    assign wake_irq  = |status;
endmodule

// File: rtl/wgk_checker.sv
`timescale 1ns/1ps
module wgk_checker #(
    parameter int N = 8
) (
    input logic         sys_clk,
    input logic         slow_clk,
    input logic         rst,
    input logic         cstop_req,
    input logic         cstop_ack,
    input logic         en_sys,
    input logic         en_slow,
    input logic         bus_req,
    input logic         gated,
    input logic         null_ack,
    input logic         reg_live,
    input logic         bus_ack,
    input logic [N-1:0] bus_rdata,
    input logic         bus_err
);
    a_r1_exclusive_sys: assert property (@(posedge sys_clk) disable iff (rst)
        !(en_sys && en_slow));

    a_r1_exclusive_slow: assert property (@(posedge slow_clk) disable iff (rst)
        !(en_sys && en_slow));

    a_r3_ack_rises: assert property (@(posedge sys_clk) disable iff (rst)
        cstop_req |=> cstop_ack);

    a_r3_ack_falls: assert property (@(posedge sys_clk) disable iff (rst)
        !cstop_req |=> !cstop_ack);

    a_r5_null_takes_gated: assert property (@(posedge sys_clk) disable iff (rst)
        (bus_req && gated) |=> (null_ack && bus_ack));

    a_r5_null_zero_data: assert property (@(posedge sys_clk) disable iff (rst)
        null_ack |-> (bus_rdata == '0 && !bus_err));

    a_r6_single_responder: assert property (@(posedge sys_clk) disable iff (rst)
        !(null_ack && reg_live));
endmodule

bind wake_gpio_keeper wgk_checker #(.N(NUM_PINS)) u_wgk_checker (
    .sys_clk(sys_clk), .slow_clk(slow_clk), .rst(rst),
    .cstop_req(cstop_req), .cstop_ack(cstop_ack),
    .en_sys(en_sys), .en_slow(en_slow), .bus_req(bus_req),
    .gated(gated), .null_ack(null_ack), .reg_live(reg_live),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
);

// File: tb/test_wake_gpio_keeper.sv
`timescale 1ns/1ps
module test_wake_gpio_keeper;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 66;
    localparam int N           = 8;

    logic         sys_clk, slow_clk, rst, sys_run;
    logic         wake_en, slow_sel, cstop_req, cstop_ack;
    logic         gpio_clk, mux_done, wake_irq;
    logic [N-1:0] pin_in, bus_wdata, bus_rdata;
    logic         bus_req, bus_we, bus_ack, bus_err;

    int           checks, fails;
    logic [N-1:0] expect_st, rd;
    logic         ak;
    time          t1, t2;

    wake_gpio_keeper #(.NUM_PINS(N)) i_wake_gpio_keeper (
        .sys_clk(sys_clk), .slow_clk(slow_clk), .rst(rst), .wake_en(wake_en),
        .slow_sel(slow_sel), .cstop_req(cstop_req), .cstop_ack(cstop_ack),
        .gpio_clk(gpio_clk), .mux_done(mux_done), .pin_in(pin_in),
        .wake_irq(wake_irq), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err)
    );

    initial begin
        sys_clk = 1'b0;
        forever begin
            #(CLK_PERIOD/2);
            if (sys_run) sys_clk = ~sys_clk;
        end
    end

    initial begin
        slow_clk = 1'b0;
        forever #(SLOW_PERIOD/2) slow_clk = ~slow_clk;
    end

    function automatic logic [N-1:0] w1c_expect(logic [N-1:0] old, logic [N-1:0] clr,
                                                logic [N-1:0] set);
        return (old & ~clr) | set;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic we, input logic [N-1:0] wd,
                            output logic [N-1:0] rdo, output logic ako);
        bus_req = 1'b1; bus_we = we; bus_wdata = wd;
        @(negedge sys_clk);
        rdo = bus_rdata; ako = bus_ack;
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge sys_clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            @(negedge sys_clk);
            if (mux_done) break;
        end
    endtask

    task automatic read_expect(input string tag, input logic [N-1:0] exp);
        bus_xfer(1'b0, '0, rd, ak);
        chk({tag, " ack"}, ak, 1);
        chk({tag, " data"}, rd, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e));
        checks = 0; fails = 0; sys_run = 1'b1;
        rst = 1'b1; wake_en = 1'b1; slow_sel = 1'b0; cstop_req = 1'b0;
        pin_in = '0; bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        expect_st = '0;
        wait_neg(40);
        rst = 1'b0;
        wait_neg(2);

        // R2 reset state
        chk("R2 mux_done", mux_done, 1);
        chk("R2 cstop_ack", cstop_ack, 0);
        chk("R2 wake_irq", wake_irq, 0);
        chk("R2 bus_err", bus_err, 0);
        read_expect("R2 status", '0);

        // R7 single-sample pulse ignored
        pin_in[1] = 1'b1; wait_neg(1); pin_in[1] = 1'b0;
        wait_neg(6);
        read_expect("R7 pulse ignored", '0);

        // R7 latency of a rising edge
        pin_in[2] = 1'b1;
        wait_neg(3);
        chk("R7 not before edge k+3", wake_irq, 0);
        wait_neg(1);
        chk("R7 set after edge k+3", wake_irq, 1);
        expect_st = w1c_expect(expect_st, '0, 8'h04);
        read_expect("R7 rising", expect_st);

        // R6 clear, R8 irq low
        bus_xfer(1'b1, 8'h04, rd, ak);
        chk("R6 write ack", ak, 1);
        expect_st = w1c_expect(expect_st, 8'h04, '0);
        read_expect("R6 cleared", expect_st);
        chk("R8 irq low", wake_irq, 0);

        // R7 falling edge
        pin_in[2] = 1'b0;
        wait_neg(5);
        expect_st = w1c_expect(expect_st, '0, 8'h04);
        read_expect("R7 falling", expect_st);
        chk("R8 irq high", wake_irq, 1);

        // random rounds
        for (int r = 0; r < 25; r++) begin
            logic [N-1:0] held, pulse, clr;
            held  = N'($urandom);
            pulse = N'($urandom) & ~held;
            clr   = N'($urandom);
            pin_in = pin_in ^ held ^ pulse;
            wait_neg(1);
            pin_in = pin_in ^ pulse;
            wait_neg(5);
            expect_st = w1c_expect(expect_st, '0, held);
            read_expect("R7 random status", expect_st);
            chk("R8 random irq", wake_irq, (expect_st != 0) ? 1 : 0);
            bus_xfer(1'b1, clr, rd, ak);
            expect_st = w1c_expect(expect_st, clr, '0);
            read_expect("R6 random clear", expect_st);
        end

        // R9 set and clear on the same edge
        bus_xfer(1'b1, '1, rd, ak);
        expect_st = '0;
        pin_in[0] = ~pin_in[0];
        wait_neg(5);
        expect_st = w1c_expect(expect_st, '0, 8'h01);
        pin_in[0] = ~pin_in[0];
        wait_neg(3);
        bus_xfer(1'b1, 8'h01, rd, ak);
        expect_st = w1c_expect(expect_st, 8'h01, 8'h01);
        read_expect("R9 set wins", expect_st);
        bus_xfer(1'b1, 8'h01, rd, ak);
        expect_st = '0;
        read_expect("R9 later clear", expect_st);

        // R3 and R5: stop acknowledged with wakeup enabled
        cstop_req = 1'b1;
        wait_neg(1);
        chk("R3 ack follows", cstop_ack, 1);
        pin_in[4] = ~pin_in[4];
        wait_neg(6);
        chk("R3 detection runs", wake_irq, 1);
        read_expect("R5 null read", '0);
        bus_xfer(1'b1, '1, rd, ak);
        chk("R5 null write ack", ak, 1);
        chk("R5 null err", bus_err, 0);
        cstop_req = 1'b0;
        wait_neg(1);
        chk("R3 ack drops", cstop_ack, 0);
        wait_neg(1);
        expect_st = 8'h10;
        read_expect("R5 write ignored", expect_st);
        bus_xfer(1'b1, '1, rd, ak);
        expect_st = '0;

        // R4: wakeup disabled stops detection clock
        wake_en = 1'b0;
        cstop_req = 1'b1;
        wait_neg(3);
        pin_in[5] = ~pin_in[5];
        wait_neg(10);
        chk("R4 frozen", wake_irq, 0);
        cstop_req = 1'b0;
        wait_neg(10);
        chk("R4 resumes", wake_irq, 1);
        expect_st = 8'h20;
        read_expect("R4 late event", expect_st);
        bus_xfer(1'b1, '1, rd, ak);
        expect_st = '0;
        wake_en = 1'b1;

        // R5: mux on slow source, status not reachable
        pin_in[6] = ~pin_in[6];
        wait_neg(5);
        slow_sel = 1'b1;
        wait_done();
        chk("R1 done on slow", mux_done, 1);
        read_expect("R5 slow null", '0);
        slow_sel = 1'b0;
        wait_done();
        chk("R1 done on sys", mux_done, 1);
        expect_st = 8'h40;
        read_expect("R5 status kept", expect_st);
        bus_xfer(1'b1, '1, rd, ak);
        expect_st = '0;
        wait_neg(1);

        // R10 and R1: deep sleep on slow clock
        cstop_req = 1'b1;
        wait_neg(1);
        slow_sel = 1'b1;
        wait_done();
        sys_run = 1'b0;
        #(CLK_PERIOD * 3);
        @(posedge gpio_clk); t1 = $time;
        @(posedge gpio_clk); t2 = $time;
        chk("R1 slow period", longint'(t2 - t1), SLOW_PERIOD);
        chk("R10 irq idle", wake_irq, 0);
        pin_in[7] = ~pin_in[7];
        for (int i = 0; i < 5; i++) @(posedge gpio_clk);
        #1;
        chk("R10 wake in sleep", wake_irq, 1);
        sys_run = 1'b1;
        wait_neg(2);
        slow_sel = 1'b0;
        wait_done();
        @(posedge gpio_clk); t1 = $time;
        @(posedge gpio_clk); t2 = $time;
        chk("R1 sys period", longint'(t2 - t1), CLK_PERIOD);
        @(negedge sys_clk);
        cstop_req = 1'b0;
        wait_neg(2);
        expect_st = 8'h80;
        read_expect("R10 source bit", expect_st);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule